// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block finds the settings of a fractional-free PLL and its output divider that bring the produced clock closest to a requested frequency. After a start pulse it takes a snapshot of the target frequency in hertz and of a flag that selects between a pixel-rate output and a serial-rate output. It then walks up to three candidate reference clocks, each given as an integer rate in hertz plus a present flag. For every usable reference it steps through the pre-divider M, the feedback multiplier N, the post-divide exponent E and an integer output divider DIV. It keeps the candidate with the smallest absolute frequency error.

When the search ends, the engine pulses `done` for one cycle. It then holds the winning M, N, E, DIV, the reference index and the error. It also holds two packed control words that a register stage can copy straight into the PLL and divider controls. All quotients come from one shared serial divider, so a search takes from a few hundred to some tens of thousands of cycles, depending on how wide the legal ranges are and how soon an exact hit turns up. The target must be nonzero.

Top module: `pll_search`

## Requirements
- R1: A reference is skipped when its present flag is low, or when its rate is below 12,000,000 Hz or above 192,000,000 Hz.
- R2: For a reference rate fin, M steps from max(1, ceil(fin/24 MHz)) up to min(8, floor(fin/12 MHz)) inclusive.
- R3: For each M, with fpfd = floor(fin/M), N steps from max(60, ceil(900 MHz/fpfd)) while N < min(120, floor(1800 MHz/fpfd)), and fvco = fpfd·N.
- R4: E takes values up to 2. It starts at 1 when fvco > 1,039,500,000 Hz and at 0 otherwise.
- R5: fout = floor(fvco/2^E). When the dot-clock-only flag is low, this value is then divided by 7 (integer division).
- R6: DIV = max(1, floor((fout + floor(target/2))/target)). The candidate error is |floor(fout/DIV) − target|.
- R7: A candidate becomes the new best only when its error is strictly below the best so far. The best error starts at 0xFFFFFFFF. The search ends as soon as a candidate with error 0 is taken.
- R8: References are searched in index order 0, 1, 2. The best is kept across references, so on equal error the lower index wins. A later reference with a smaller error replaces an earlier one.
- R9: pll_word (20 bits) has bit 0 = enable = 1, bits 2:1 = reference index, bit 3 = clock-out = 1, bits 10:4 = N−1, bits 14:11 = M−1. When E > 0 it also has bits 16:15 = E−1 and bits 17 and 18 = 1. Bit 19 = 1 when dot-clock-only is set.
- R10: div_word (34 bits) has bits 31:0 = DIV−1, bit 32 = select = 1 and bit 33 = divider reset release = 1 when DIV > 1. It is all zeros when DIV = 1.
- R11: When no reference yields a candidate, done still pulses. valid stays low, the error reads 0xFFFFFFFF, and M, N, E, DIV, the index and both words read zero.
- R12: busy rises the cycle after an accepted start and stays high until done. done is a one-cycle pulse during which busy is already low. A start while busy is ignored and produces no further done.
- R13: After reset, busy, done and valid are low and the error output is 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (taken only while idle) |
| target | input | 32 | Requested output frequency in Hz, nonzero |
| dot_only | input | 1 | 1: pixel-rate output (no divide by 7) |
| ref_rate | input | 3×32 | Rate in Hz of each candidate reference |
| ref_present | input | 3 | Present flag per reference |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| valid | output | 1 | At least one candidate was found |
| res_m | output | 4 | Chosen pre-divider M |
| res_n | output | 7 | Chosen multiplier N |
| res_e | output | 2 | Chosen post-divide exponent E |
| res_div | output | 32 | Chosen output divider DIV |
| res_src | output | 2 | Chosen reference index |
| res_err | output | 32 | Absolute error in Hz of the chosen setting |
| pll_word | output | 20 | Packed PLL control word |
| div_word | output | 34 | Packed output divider control word |

## Verification
Only busy has a fixed latency: it must be high one cycle after the start edge. The results become due in the cycle of the done pulse, and the number of cycles until then depends on the data, because each candidate costs several serial divisions. The bench therefore samples at the falling clock edge in every cycle between start and done. It requires busy in each of those cycles, compares every result field and both words against its own behavioural search at the done cycle, and checks that done falls again one cycle later. For an ignored start it keeps watching for a stretch after done to confirm that no second pulse comes.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    // Sequencer states of the search engine
    typedef enum logic [3:0] {
        S_IDLE,
        S_SRC,
        S_LAUNCH,
        S_WAIT,
        S_MLOOP,
        S_NLOOP,
        S_ELOOP,
        S_CMP,
        S_FINISH
    } srch_state_t;

    // Which quotient the shared divider is producing
    typedef enum logic [2:0] {
        OP_MLO,
        OP_MHI,
        OP_FPFD,
        OP_NLO,
        OP_NHI,
        OP_LANE,
        OP_ROUND,
        OP_OUT
    } div_op_t;

endpackage

// File: rtl/pll_search_div.sv
// Serial restoring divider, one quotient bit per cycle.
module pll_search_div #(
    parameter int DW = 33,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [DW-1:0] quo,
    output logic          done
);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [DW-1:0] quo;
        logic [DW-1:0] rem;
        logic [DW-1:0] den;
        logic [DW-1:0] num;
    } div_regs_t;

    div_regs_t r_q, r_d;
    logic [DW:0] shl;
    logic [DW:0] trial;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        shl      = {r_q.rem, r_q.quo[DW-1]};
        trial    = shl - {1'b0, r_q.den};
        if (start) begin
            r_d.busy = 1'b1;
            r_d.quo  = num;
            r_d.num  = num;
            r_d.den  = den;
            r_d.rem  = '0;
            r_d.cnt  = CW'(DW);
        end else if (r_q.busy) begin
            if (!trial[DW]) begin
                r_d.rem = trial[DW-1:0];
                r_d.quo = {r_q.quo[DW-2:0], 1'b1};
            end else begin
                r_d.rem = shl[DW-1:0];
                r_d.quo = {r_q.quo[DW-2:0], 1'b0};
            end
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == CW'(1)) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign quo  = r_q.quo;
    assign done = r_q.done;

    // Quotient and remainder reconstruct the latched dividend (basis of R6)
    p_div_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (({{DW{1'b0}}, r_q.quo} * {{DW{1'b0}}, r_q.den}
                       + {{DW{1'b0}}, r_q.rem}) == {{DW{1'b0}}, r_q.num}));

endmodule

// File: rtl/pll_search_pack.sv
// Packs the chosen settings into the PLL and divider control words.
module pll_search_pack #(
    parameter int FW = 32,
    parameter int SW = 2,
    parameter int MW = 4,
    parameter int NW = 7,
    parameter int EW = 2,
    localparam int B_SRC  = 1,
    localparam int B_CLKO = B_SRC + SW,
    localparam int B_N    = B_CLKO + 1,
    localparam int B_M    = B_N + NW,
    localparam int B_E    = B_M + MW,
    localparam int B_PDP  = B_E + EW,
    localparam int B_PDS  = B_PDP + 1,
    localparam int B_OCK  = B_PDS + 1,
    localparam int PLLW   = B_OCK + 1
) (
    input  logic            found,
    input  logic            dot,
    input  logic [SW-1:0]   src,
    input  logic [MW-1:0]   m,
    input  logic [NW-1:0]   n,
    input  logic [EW-1:0]   e,
    input  logic [FW-1:0]   div,
    output logic [PLLW-1:0] pll_word,
    output logic [FW+1:0]   div_word
);

    logic [NW-1:0] n_m1;
    logic [MW-1:0] m_m1;
    logic [EW-1:0] e_m1;
    logic [FW-1:0] d_m1;

    always_comb begin
        pll_word = '0;
        div_word = '0;
        n_m1     = n - 1'b1;
        m_m1     = m - 1'b1;
        e_m1     = e - 1'b1;
        d_m1     = div - 1'b1;
        if (found) begin
            pll_word[0]              = 1'b1;
            pll_word[B_SRC +: SW]    = src;
            pll_word[B_CLKO]         = 1'b1;
            pll_word[B_N +: NW]      = n_m1;
            pll_word[B_M +: MW]      = m_m1;
            if (e != '0) begin
                pll_word[B_E +: EW]  = e_m1;
                pll_word[B_PDP]      = 1'b1;
                pll_word[B_PDS]      = 1'b1;
            end
            pll_word[B_OCK]          = dot;
            if (div > FW'(1)) begin
                div_word[FW-1:0]     = d_m1;
                div_word[FW]         = 1'b1;
                div_word[FW+1]       = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pll_search.sv
module pll_search
    import pll_search_pkg::*;
#(
    parameter int          FW       = 32,
    parameter int          NSRC     = 3,
    parameter int          M_LIM    = 8,
    parameter int          N_LO     = 60,
    parameter int          N_HI     = 120,
    parameter int          E_TOP    = 3,
    parameter int          LANE     = 7,
    parameter int unsigned FIN_LO   = 12_000_000,
    parameter int unsigned FIN_HI   = 192_000_000,
    parameter int unsigned PFD_LO   = 12_000_000,
    parameter int unsigned PFD_HI   = 24_000_000,
    parameter int unsigned VCO_LO   = 900_000_000,
    parameter int unsigned VCO_HI   = 1_800_000_000,
    parameter int unsigned FOUT_CAP = 1_039_500_000,
    localparam int DW   = FW + 1,
    localparam int SW   = $clog2(NSRC + 1),
    localparam int MW   = $clog2(M_LIM + 2),
    localparam int NW   = $clog2(N_HI + 1),
    localparam int EW   = $clog2(E_TOP + 1),
    localparam int PLLW = 1 + SW + 1 + NW + MW + EW + 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [FW-1:0]             target,
    input  logic                      dot_only,
    input  logic [NSRC-1:0][FW-1:0]   ref_rate,
    input  logic [NSRC-1:0]           ref_present,
    output logic                      busy,
    output logic                      done,
    output logic                      valid,
    output logic [MW-1:0]             res_m,
    output logic [NW-1:0]             res_n,
    output logic [EW-1:0]             res_e,
    output logic [FW-1:0]             res_div,
    output logic [SW-1:0]             res_src,
    output logic [FW-1:0]             res_err,
    output logic [PLLW-1:0]           pll_word,
    output logic [FW+1:0]             div_word
);

    typedef struct packed {
        srch_state_t   st;
        div_op_t       op;
        logic          busy;
        logic          done;
        logic          found;
        logic          dot;
        logic [FW-1:0] tgt;
        logic [SW-1:0] src;
        logic [FW-1:0] fin;
        logic [MW-1:0] m;
        logic [MW-1:0] m_max;
        logic [FW-1:0] fpfd;
        logic [NW-1:0] n;
        logic [NW-1:0] n_max;
        logic [FW-1:0] fvco;
        logic [EW-1:0] e;
        logic [FW-1:0] fout;
        logic [FW-1:0] div;
        logic [FW-1:0] ach;
        logic [MW-1:0] b_m;
        logic [NW-1:0] b_n;
        logic [EW-1:0] b_e;
        logic [FW-1:0] b_div;
        logic [SW-1:0] b_src;
        logic [FW-1:0] b_err;
        logic [DW-1:0] num;
        logic [DW-1:0] den;
    } srch_regs_t;

    srch_regs_t r_q, r_d;

    logic [DW-1:0]    dq;
    logic             d_done;
    logic [FW-1:0]    rate_sel;
    logic             pres_sel;
    logic [FW+NW-1:0] prod;
    logic [FW-1:0]    shifted;
    logic [FW-1:0]    diff;
    logic [DW-1:0]    half_tgt;
    logic [FW-1:0]    div_new;

    pll_search_div #(.DW(DW)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (r_q.st == S_LAUNCH),
        .num   (r_q.num),
        .den   (r_q.den),
        .quo   (dq),
        .done  (d_done)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;

        rate_sel = '0;
        pres_sel = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (r_q.src == SW'(i)) begin
                rate_sel = ref_rate[i];
                pres_sel = ref_present[i];
            end
        end

        prod     = (FW+NW)'(r_q.fpfd) * (FW+NW)'(r_q.n);
        shifted  = r_q.fvco >> r_q.e;
        diff     = (r_q.ach >= r_q.tgt) ? (r_q.ach - r_q.tgt) : (r_q.tgt - r_q.ach);
        half_tgt = {1'b0, r_q.tgt >> 1};
        div_new  = (dq == '0) ? FW'(1) : dq[FW-1:0];

        case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.busy  = 1'b1;
                    r_d.found = 1'b0;
                    r_d.tgt   = target;
                    r_d.dot   = dot_only;
                    r_d.src   = '0;
                    r_d.b_m   = '0;
                    r_d.b_n   = '0;
                    r_d.b_e   = '0;
                    r_d.b_div = '0;
                    r_d.b_src = '0;
                    r_d.b_err = '1;
                    r_d.st    = S_SRC;
                end
            end

            S_SRC: begin
                if (r_q.src >= SW'(NSRC)) begin
                    r_d.st = S_FINISH;
                end else if (!pres_sel || rate_sel < FW'(FIN_LO) || rate_sel > FW'(FIN_HI)) begin
                    r_d.src = r_q.src + 1'b1;
                end else begin
                    r_d.fin = rate_sel;
                    r_d.num = DW'(rate_sel) + DW'(PFD_HI) - DW'(1);
                    r_d.den = DW'(PFD_HI);
                    r_d.op  = OP_MLO;
                    r_d.st  = S_LAUNCH;
                end
            end

            S_LAUNCH: begin
                r_d.st = S_WAIT;
            end

            S_WAIT: begin
                if (d_done) begin
                    case (r_q.op)
                        OP_MLO: begin
                            r_d.m   = (dq == '0) ? MW'(1) : dq[MW-1:0];
                            r_d.num = {1'b0, r_q.fin};
                            r_d.den = DW'(PFD_LO);
                            r_d.op  = OP_MHI;
                            r_d.st  = S_LAUNCH;
                        end
                        OP_MHI: begin
                            r_d.m_max = (dq > DW'(M_LIM)) ? MW'(M_LIM) : dq[MW-1:0];
                            r_d.st    = S_MLOOP;
                        end
                        OP_FPFD: begin
                            r_d.fpfd = dq[FW-1:0];
                            r_d.num  = DW'(VCO_LO) + {1'b0, dq[FW-1:0]} - DW'(1);
                            r_d.den  = {1'b0, dq[FW-1:0]};
                            r_d.op   = OP_NLO;
                            r_d.st   = S_LAUNCH;
                        end
                        OP_NLO: begin
                            if (dq < DW'(N_LO)) begin
                                r_d.n = NW'(N_LO);
                            end else if (dq > DW'(N_HI)) begin
                                r_d.n = NW'(N_HI);
                            end else begin
                                r_d.n = dq[NW-1:0];
                            end
                            r_d.num = DW'(VCO_HI);
                            r_d.den = {1'b0, r_q.fpfd};
                            r_d.op  = OP_NHI;
                            r_d.st  = S_LAUNCH;
                        end
                        OP_NHI: begin
                            r_d.n_max = (dq > DW'(N_HI)) ? NW'(N_HI) : dq[NW-1:0];
                            r_d.st    = S_NLOOP;
                        end
                        OP_LANE: begin
                            r_d.fout = dq[FW-1:0];
                            r_d.num  = {1'b0, dq[FW-1:0]} + half_tgt;
                            r_d.den  = {1'b0, r_q.tgt};
                            r_d.op   = OP_ROUND;
                            r_d.st   = S_LAUNCH;
                        end
                        OP_ROUND: begin
                            r_d.div = div_new;
                            r_d.num = {1'b0, r_q.fout};
                            r_d.den = {1'b0, div_new};
                            r_d.op  = OP_OUT;
                            r_d.st  = S_LAUNCH;
                        end
                        OP_OUT: begin
                            r_d.ach = dq[FW-1:0];
                            r_d.st  = S_CMP;
                        end
                        default: r_d.st = S_FINISH;
                    endcase
                end
            end

            S_MLOOP: begin
                if (r_q.m > r_q.m_max) begin
                    r_d.src = r_q.src + 1'b1;
                    r_d.st  = S_SRC;
                end else begin
                    r_d.num = {1'b0, r_q.fin};
                    r_d.den = DW'(r_q.m);
                    r_d.op  = OP_FPFD;
                    r_d.st  = S_LAUNCH;
                end
            end

            S_NLOOP: begin
                if (r_q.n >= r_q.n_max) begin
                    r_d.m  = r_q.m + 1'b1;
                    r_d.st = S_MLOOP;
                end else begin
                    r_d.fvco = prod[FW-1:0];
                    r_d.e    = (prod > (FW+NW)'(FOUT_CAP)) ? EW'(1) : '0;
                    r_d.st   = S_ELOOP;
                end
            end

            S_ELOOP: begin
                if (r_q.e >= EW'(E_TOP)) begin
                    r_d.n  = r_q.n + 1'b1;
                    r_d.st = S_NLOOP;
                end else if (r_q.dot) begin
                    r_d.fout = shifted;
                    r_d.num  = {1'b0, shifted} + half_tgt;
                    r_d.den  = {1'b0, r_q.tgt};
                    r_d.op   = OP_ROUND;
                    r_d.st   = S_LAUNCH;
                end else begin
                    r_d.num  = {1'b0, shifted};
                    r_d.den  = DW'(LANE);
                    r_d.op   = OP_LANE;
                    r_d.st   = S_LAUNCH;
                end
            end

            S_CMP: begin
                r_d.e  = r_q.e + 1'b1;
                r_d.st = S_ELOOP;
                if (diff < r_q.b_err) begin
                    r_d.found = 1'b1;
                    r_d.b_m   = r_q.m;
                    r_d.b_n   = r_q.n;
                    r_d.b_e   = r_q.e;
                    r_d.b_div = r_q.div;
                    r_d.b_src = r_q.src;
                    r_d.b_err = diff;
                    if (diff == '0) begin
                        r_d.st = S_FINISH;
                    end
                end
            end

            S_FINISH: begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
                r_d.st   = S_IDLE;
            end

            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= S_IDLE;
            r_q.op    <= OP_MLO;
            r_q.b_err <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    pll_search_pack #(
        .FW(FW), .SW(SW), .MW(MW), .NW(NW), .EW(EW)
    ) i_pack (
        .found    (r_q.found),
        .dot      (r_q.dot),
        .src      (r_q.b_src),
        .m        (r_q.b_m),
        .n        (r_q.b_n),
        .e        (r_q.b_e),
        .div      (r_q.b_div),
        .pll_word (pll_word),
        .div_word (div_word)
    );

    assign busy    = r_q.busy;
    assign done    = r_q.done;
    assign valid   = r_q.found;
    assign res_m   = r_q.b_m;
    assign res_n   = r_q.b_n;
    assign res_e   = r_q.b_e;
    assign res_div = r_q.b_div;
    assign res_src = r_q.b_src;
    assign res_err = r_q.b_err;

    // R12: an accepted start makes the engine busy on the next cycle
    p_start_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R12: done comes out of a busy period with busy already low
    p_done_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R7: the best error never grows inside one search
    p_err_nonincr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (res_err <= $past(res_err)));

    // R2: a reported M lies in the legal window
    p_m_bounds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && valid) |-> (res_m >= MW'(1) && res_m <= MW'(M_LIM)));

    // R3: a reported N lies in the legal window
    p_n_bounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && valid) |-> (res_n >= NW'(N_LO) && res_n < NW'(N_HI)));

    // R4: a reported E stays below the exponent limit
    p_e_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && valid) |-> (res_e < EW'(E_TOP)));

    // R11: a search without candidates leaves empty words and a full error
    p_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !valid) |-> (res_err == '1 && pll_word == '0 && div_word == '0));

endmodule

// File: tb/test_pll_search.sv
module test_pll_search;

    localparam int  FW       = 32;
    localparam longint LIMIT = 80000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [FW-1:0]     target = '0;
    logic              dot_only = 1'b0;
    logic [2:0][FW-1:0] ref_rate = '0;
    logic [2:0]        ref_present = '0;
    logic              busy, done, valid;
    logic [3:0]        res_m;
    logic [6:0]        res_n;
    logic [1:0]        res_e;
    logic [FW-1:0]     res_div;
    logic [1:0]        res_src;
    logic [FW-1:0]     res_err;
    logic [19:0]       pll_word;
    logic [FW+1:0]     div_word;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pll_search i_pll_search (
        .clk(clk), .rst_n(rst_n), .start(start), .target(target),
        .dot_only(dot_only), .ref_rate(ref_rate), .ref_present(ref_present),
        .busy(busy), .done(done), .valid(valid), .res_m(res_m), .res_n(res_n),
        .res_e(res_e), .res_div(res_div), .res_src(res_src), .res_err(res_err),
        .pll_word(pll_word), .div_word(div_word)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural search following the requirement text
    task automatic model(input longint tgt, input bit dot, input longint rt[3],
                         input bit [2:0] pr, output bit fnd, output longint bm,
                         output longint bn, output longint be, output longint bd,
                         output longint bs, output longint berr);
        bit stop = 0;
        fnd = 0; bm = 0; bn = 0; be = 0; bd = 0; bs = 0;
        berr = 64'hFFFF_FFFF;
        for (int s = 0; s < 3; s++) begin
            longint lo_m, hi_m;
            if (stop || !pr[s] || rt[s] < 12000000 || rt[s] > 192000000) continue;
            lo_m = (rt[s] + 23999999) / 24000000;
            if (lo_m < 1) lo_m = 1;
            hi_m = rt[s] / 12000000;
            if (hi_m > 8) hi_m = 8;
            for (longint m = lo_m; m <= hi_m && !stop; m++) begin
                longint fp = rt[s] / m;
                longint lo_n = (900000000 + fp - 1) / fp;
                longint hi_n = 1800000000 / fp;
                if (lo_n < 60) lo_n = 60;
                if (hi_n > 120) hi_n = 120;
                for (longint n = lo_n; n < hi_n && !stop; n++) begin
                    longint fv = fp * n;
                    for (longint e = (fv > 1039500000) ? 1 : 0; e < 3 && !stop; e++) begin
                        longint fo = fv >> e;
                        longint d, q, df;
                        if (!dot) fo = fo / 7;
                        d = (fo + tgt / 2) / tgt;
                        if (d < 1) d = 1;
                        q = fo / d;
                        df = (q > tgt) ? q - tgt : tgt - q;
                        if (df < berr) begin
                            berr = df; bm = m; bn = n; be = e; bd = d; bs = s; fnd = 1;
                            if (df == 0) stop = 1;
                        end
                    end
                end
            end
        end
    endtask

    task automatic run_case(input string name, input longint tgt, input bit dot,
                            input longint r0, input longint r1, input longint r2,
                            input bit [2:0] pr, input bit poke, input longint alt,
                            input longint want_src, input longint want_err);
        longint rt[3];
        bit fnd;
        longint bm, bn, be, bd, bs, berr, xp_pll, xp_div;
        longint cyc = 0;
        bit lost_busy = 0;
        rt[0] = r0; rt[1] = r1; rt[2] = r2;
        $display("case %s", name);
        target      = FW'(tgt);
        dot_only    = dot;
        ref_rate[0] = FW'(r0);
        ref_rate[1] = FW'(r1);
        ref_rate[2] = FW'(r2);
        ref_present = pr;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R12 busy one cycle after start", longint'(busy), 1);
        while (!done && cyc < LIMIT) begin
            if (!busy) lost_busy = 1;
            if (poke && cyc == 100) begin
                target = FW'(alt);
                start  = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (cyc >= LIMIT) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=done", cyc);
        end
        chk("R12 busy held until done", longint'(lost_busy), 0);
        chk("R12 busy low at done", longint'(busy), 0);
        model(tgt, dot, rt, pr, fnd, bm, bn, be, bd, bs, berr);
        chk("R11 valid", longint'(valid), longint'(fnd));
        chk("R7 error", longint'(res_err), berr);
        chk("R2 M", longint'(res_m), bm);
        chk("R3 N", longint'(res_n), bn);
        chk("R4 E", longint'(res_e), be);
        chk("R6 DIV", longint'(res_div), bd);
        chk("R8 source", longint'(res_src), bs);
        if (want_src >= 0) chk("R8 source by hand", longint'(res_src), want_src);
        if (want_err >= 0) chk("R7 error by hand", longint'(res_err), want_err);
        xp_pll = 0;
        xp_div = 0;
        if (fnd) begin
            xp_pll = 1 | (bs << 1) | (1 << 3) | ((bn - 1) << 4) | ((bm - 1) << 11);
            if (be > 0) xp_pll = xp_pll | ((be - 1) << 15) | (1 << 17) | (1 << 18);
            if (dot) xp_pll = xp_pll | (1 << 19);
            if (bd > 1) xp_div = (bd - 1) | (longint'(1) << 32) | (longint'(1) << 33);
        end
        chk("R9 pll_word", longint'(pll_word), xp_pll);
        chk("R10 div_word", longint'(div_word), xp_div);
        @(negedge clk);
        chk("R12 done is one cycle", longint'(done), 0);
        if (poke) begin
            bit extra = 0;
            for (int k = 0; k < 400; k++) begin
                if (done || busy) extra = 1;
                @(negedge clk);
            end
            chk("R12 start while busy ignored", longint'(extra), 0);
            chk("R12 result of first target kept", longint'(res_err), berr);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R13 busy after reset", longint'(busy), 0);
        chk("R13 done after reset", longint'(done), 0);
        chk("R13 valid after reset", longint'(valid), 0);
        chk("R13 error after reset", longint'(res_err), 64'hFFFF_FFFF);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11: nothing present
        run_case("no reference", 50000000, 0, 24000000, 24000000, 24000000,
                 3'b000, 0, 0, 0, 64'hFFFF_FFFF);
        // R1: present references just outside the allowed range
        run_case("out of range", 50000000, 0, 11999999, 192000001, 0,
                 3'b011, 0, 0, 0, 64'hFFFF_FFFF);
        // R5 dot mode, exact hit on first candidate: M=1 N=60 E=1 DIV=10
        run_case("dot exact", 72000000, 1, 24000000, 0, 0, 3'b001, 0, 0, 0, 0);
        chk("R5 dot M", longint'(res_m), 1);
        chk("R4 dot E start", longint'(res_e), 1);
        chk("R10 dot DIV", longint'(res_div), 10);
        // R5 serial mode on the crystal only
        run_case("crystal lane", 65000000, 0, 0, 0, 20000000, 3'b100, 0, 0, 2, -1);
        // R8 tie between equal references keeps index 0
        run_case("tie", 33333333, 0, 27000000, 27000000, 0, 3'b011, 0, 0, 0, -1);
        // R8 later exact reference beats earlier inexact one; DIV=1 path
        run_case("later wins", 120000000, 0, 27000000, 24000000, 0, 3'b011, 0, 0, 1, 0);
        chk("R10 DIV one", longint'(res_div), 1);
        // R12 second start during a search
        run_case("busy start", 65000000, 0, 0, 0, 20000000, 3'b100, 1, 40000000, 2, -1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL global watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule